// File: doc/BRIEF.md
# Two-Phase Redundant-Digit Converter Sequencer

This block is the digital sequencer and result decoder that sits beside one switched-capacitor converter core. The core is used for two passes. In the first pass it integrates input samples. In the second pass it runs as a conventional redundant signed-digit cyclic stage. On every step the core's two comparators report where the present value lies against plus and minus half the reference. The block turns that pair into a ternary digit and drives back a switch code that tells the core which operation to apply at the next clock edge.

During the integration pass, every digit is added into a signed tally. That tally supplies the most significant part of the result. During the cyclic pass, the digits are weighted by descending powers of two. This folds the redundant representation into a signed binary fraction. The two parts are then combined, clamped to the output width and presented together with a one-cycle done pulse.

A conversion is started by a single-cycle start pulse. Until the sequence returns to idle, the block ignores any further start pulses.

Top module: `rsd_conv_seq`

## Requirements
- R1: The step digit is +1 when only the upper comparator is high, −1 when only the lower comparator is high, and 0 when neither or both are high.
- R2: A start pulse in the idle phase raises the residue-clear output for that same cycle. It also clears the step counter, the integration tally and the fractional sum.
- R3: In the integration phase the switch code is 1 (add input) for digit 0, 2 (add input, subtract reference) for digit +1, and 3 (add input, add reference) for digit −1.
- R4: The phase output is encoded as 0 idle, 1 integration, 2 cyclic and 3 done. Integration lasts exactly 2^ACC_LOG cycles and the cyclic phase exactly N_LSB cycles. The done phase lasts one cycle, after which the block returns to idle.
- R5: In the cyclic phase the switch code is 4 (double) for digit 0, 5 (double, subtract reference) for digit +1, and 6 (double, add reference) for digit −1. In the idle and done phases the switch code is 0 (hold).
- R6: The result equals the integration tally times 2^N_LSB, plus the sum over the cyclic digits of t·2^(N_LSB−1−k), where k=0 is the first cyclic digit. It is a two's-complement value.
- R7: The result saturates to the signed range of N_LSB+ACC_LOG+1 bits.
- R8: Done is high for exactly the one cycle in which the phase is 3. The result changes in that cycle and holds until the next conversion completes.
- R9: A start pulse seen in the integration, cyclic or done phase has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle conversion request |
| cmp_hi | input | 1 | Core value above +Vref/2 |
| cmp_lo | input | 1 | Core value below −Vref/2 |
| clr_res | output | 1 | Clear the core residue at this edge |
| sw_code | output | 3 | Core operation for this step |
| phase | output | 2 | Current phase |
| done | output | 1 | Result valid pulse |
| result | output | N_LSB+ACC_LOG+1 | Signed conversion result |

## Verification
The bench builds the block with the default N_LSB=11 and ACC_LOG=5, which gives a 32-step integration and a 17-bit result. With these values, an all-positive digit stream exceeds the output range and an all-negative stream falls below it. A stream of 31 positive integration digits followed by all-positive cyclic digits lands exactly on the top code. Together these reach both clamp edges and the exact boundary. Mixed random streams, both-comparators-high steps, and start pulses in every busy phase cover the remaining sequencing paths.

// File: rtl/rsd_seq_pkg.sv
package rsd_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_COARSE = 2'd1,
    PH_LSB    = 2'd2,
    PH_DONE   = 2'd3
  } phase_t;

  localparam logic [2:0] SW_HOLD    = 3'd0;
  localparam logic [2:0] SW_ACC     = 3'd1;
  localparam logic [2:0] SW_ACC_SUB = 3'd2;
  localparam logic [2:0] SW_ACC_ADD = 3'd3;
  localparam logic [2:0] SW_DBL     = 3'd4;
  localparam logic [2:0] SW_DBL_SUB = 3'd5;
  localparam logic [2:0] SW_DBL_ADD = 3'd6;

  localparam logic signed [1:0] DIG_POS  = 2'sb01;
  localparam logic signed [1:0] DIG_NEG  = 2'sb11;
  localparam logic signed [1:0] DIG_ZERO = 2'sb00;
endpackage

// File: rtl/rsd_digit_dec.sv
module rsd_digit_dec
  import rsd_seq_pkg::*;
(
  input  logic              cmp_hi,
  input  logic              cmp_lo,
  output logic signed [1:0] digit
);
  always_comb begin
    unique case ({cmp_hi, cmp_lo})
      2'b10:   digit = DIG_POS;
      2'b01:   digit = DIG_NEG;
      default: digit = DIG_ZERO;
    endcase
  end
endmodule

// File: rtl/rsd_seq_ctrl.sv
module rsd_seq_ctrl
  import rsd_seq_pkg::*;
#(
  parameter int N_LSB   = 11,
  parameter int ACC_LOG = 5,
  localparam int COARSE_STEPS = 1 << ACC_LOG,
  localparam int CNT_MAX = (COARSE_STEPS > N_LSB) ? COARSE_STEPS : N_LSB,
  localparam int CNT_W   = $clog2(CNT_MAX) + 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic signed [1:0] digit,
  output phase_t            phase,
  output logic              clear,
  output logic              coarse_en,
  output logic              lsb_en,
  output logic              last_lsb,
  output logic [CNT_W-1:0]  lsb_idx,
  output logic [2:0]        sw_code
);
  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_COARSE;
          cnt_q   <= '0;
        end
        PH_COARSE: if (cnt_q == CNT_W'(COARSE_STEPS - 1)) begin
          phase_q <= PH_LSB;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        PH_LSB: if (cnt_q == CNT_W'(N_LSB - 1)) begin
          phase_q <= PH_DONE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    sw_code = SW_HOLD;
    if (phase_q == PH_COARSE) begin
      if (digit == DIG_POS)      sw_code = SW_ACC_SUB;
      else if (digit == DIG_NEG) sw_code = SW_ACC_ADD;
      else                       sw_code = SW_ACC;
    end else if (phase_q == PH_LSB) begin
      if (digit == DIG_POS)      sw_code = SW_DBL_SUB;
      else if (digit == DIG_NEG) sw_code = SW_DBL_ADD;
      else                       sw_code = SW_DBL;
    end
  end

  assign phase     = phase_q;
  assign clear     = (phase_q == PH_IDLE) && start;
  assign coarse_en = (phase_q == PH_COARSE);
  assign lsb_en    = (phase_q == PH_LSB);
  assign last_lsb  = lsb_en && (cnt_q == CNT_W'(N_LSB - 1));
  assign lsb_idx   = cnt_q;

  // R4: integration hands over to the cyclic phase only after its full count
  assert_coarse_len_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_LSB && $past(phase_q) == PH_COARSE)
      |-> $past(cnt_q) == CNT_W'(COARSE_STEPS - 1));

  // R9: a start pulse in a busy phase never restarts integration
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
    (start && (phase_q == PH_LSB || phase_q == PH_DONE)) |=> phase_q != PH_COARSE);
endmodule

// File: rtl/rsd_result_acc.sv
module rsd_result_acc
  import rsd_seq_pkg::*;
#(
  parameter int N_LSB   = 11,
  parameter int ACC_LOG = 5,
  parameter int CNT_W   = 6,
  localparam int OUT_W  = N_LSB + ACC_LOG + 1,
  localparam int SUM_W  = ACC_LOG + 2,
  localparam int LSB_W  = N_LSB + 2,
  localparam int FULL_W = SUM_W + N_LSB + 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              coarse_en,
  input  logic              lsb_en,
  input  logic              last_lsb,
  input  logic [CNT_W-1:0]  lsb_idx,
  input  logic signed [1:0] digit,
  output logic [OUT_W-1:0]  result,
  output logic              done
);
  localparam logic signed [FULL_W-1:0] MAX_F = FULL_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [FULL_W-1:0] MIN_F = -MAX_F - FULL_W'(1);

  logic signed [SUM_W-1:0]  sum_q;
  logic signed [LSB_W-1:0]  lsb_q;
  logic signed [LSB_W-1:0]  weight, term, lsb_next;
  logic [CNT_W-1:0]         shamt;
  logic signed [FULL_W-1:0] full, clamped;
  logic [OUT_W-1:0]         result_q;
  logic                     done_q;

  always_comb begin
    shamt  = CNT_W'(N_LSB - 1) - lsb_idx;
    weight = LSB_W'(1) << shamt;
    if (digit == DIG_POS)      term = weight;
    else if (digit == DIG_NEG) term = -weight;
    else                       term = '0;
    lsb_next = lsb_q + term;
    full = (FULL_W'(sum_q) <<< N_LSB) + FULL_W'(lsb_next);
    if (full > MAX_F)      clamped = MAX_F;
    else if (full < MIN_F) clamped = MIN_F;
    else                   clamped = full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q    <= '0;
      lsb_q    <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_lsb;
      if (clear) begin
        sum_q <= '0;
        lsb_q <= '0;
      end else begin
        if (coarse_en) sum_q <= sum_q + SUM_W'(digit);
        if (lsb_en)    lsb_q <= lsb_next;
      end
      if (last_lsb) result_q <= clamped[OUT_W-1:0];
    end
  end

  assign result = result_q;
  assign done   = done_q;

  // R2: a conversion start leaves both running sums at zero
  assert_clear_sums_R2: assert property (@(posedge clk) disable iff (rst)
    clear |=> (sum_q == '0 && lsb_q == '0));

  // R8: the result only moves in the cycle done is raised
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done_q |-> $stable(result_q));
endmodule

// File: rtl/rsd_conv_seq.sv
module rsd_conv_seq
  import rsd_seq_pkg::*;
#(
  parameter int N_LSB   = 11,
  parameter int ACC_LOG = 5,
  localparam int OUT_W  = N_LSB + ACC_LOG + 1,
  localparam int COARSE_STEPS = 1 << ACC_LOG,
  localparam int CNT_MAX = (COARSE_STEPS > N_LSB) ? COARSE_STEPS : N_LSB,
  localparam int CNT_W   = $clog2(CNT_MAX) + 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_hi,
  input  logic             cmp_lo,
  output logic             clr_res,
  output logic [2:0]       sw_code,
  output logic [1:0]       phase,
  output logic             done,
  output logic [OUT_W-1:0] result
);
  logic signed [1:0] digit;
  phase_t            phase_s;
  logic              clear, coarse_en, lsb_en, last_lsb;
  logic [CNT_W-1:0]  lsb_idx;

  rsd_digit_dec u_dec (
    .cmp_hi (cmp_hi),
    .cmp_lo (cmp_lo),
    .digit  (digit)
  );

  rsd_seq_ctrl #(.N_LSB(N_LSB), .ACC_LOG(ACC_LOG)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .digit     (digit),
    .phase     (phase_s),
    .clear     (clear),
    .coarse_en (coarse_en),
    .lsb_en    (lsb_en),
    .last_lsb  (last_lsb),
    .lsb_idx   (lsb_idx),
    .sw_code   (sw_code)
  );

  rsd_result_acc #(.N_LSB(N_LSB), .ACC_LOG(ACC_LOG), .CNT_W(CNT_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .coarse_en (coarse_en),
    .lsb_en    (lsb_en),
    .last_lsb  (last_lsb),
    .lsb_idx   (lsb_idx),
    .digit     (digit),
    .result    (result),
    .done      (done)
  );

  assign phase   = phase_s;
  assign clr_res = clear;

  // R3: lone upper comparator during integration selects subtract-reference
  assert_coarse_sub_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_s == PH_COARSE && cmp_hi && !cmp_lo) |-> sw_code == SW_ACC_SUB);

  // R1: both comparators high decode as a zero digit in the cyclic phase
  assert_both_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (phase_s == PH_LSB && cmp_hi && cmp_lo) |-> sw_code == SW_DBL);

  // R8: done is a single-cycle pulse aligned with the done phase
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (phase_s == PH_DONE) ##1 !done);
endmodule

// File: tb/rsd_conv_seq_bench.sv
module rsd_conv_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_LSB   = 11;
  localparam int ACC_LOG = 5;
  localparam int OUT_W   = N_LSB + ACC_LOG + 1;
  localparam int NCO     = 1 << ACC_LOG;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, cmp_hi = 1'b0, cmp_lo = 1'b0;
  logic clr_res, done;
  logic [2:0] sw_code;
  logic [1:0] phase;
  logic [OUT_W-1:0] result;

  rsd_conv_seq #(.N_LSB(N_LSB), .ACC_LOG(ACC_LOG)) u_rsd_conv_seq (
    .clk(clk), .rst(rst), .start(start), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .clr_res(clr_res), .sw_code(sw_code), .phase(phase), .done(done), .result(result)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  string ctx = "reset";

  // reference model state
  int m_ph = 0, m_cnt = 0, m_sum = 0, m_lsb = 0, m_res = 0;
  bit m_sat = 0;

  task automatic chk(input string req, input string name, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s act=%0d exp=%0d", req, ctx, name, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      finish_run();
    end
  end

  // d: -1/0/+1; both: drive both comparators high (digit 0)
  task automatic step(input bit st, input int d, input bit both);
    int dd, esw;
    longint full;
    @(negedge clk);
    start  = st;
    cmp_hi = both || (d == 1);
    cmp_lo = both || (d == -1);
    dd = both ? 0 : d;
    #1;
    // expected combinational codes (R3 / R5 / R1 digit decode)
    if (m_ph == 1)      esw = (dd == 1) ? 2 : (dd == -1) ? 3 : 1;
    else if (m_ph == 2) esw = (dd == 1) ? 5 : (dd == -1) ? 6 : 4;
    else                esw = 0;
    chk((m_ph == 2) ? "R5" : (m_ph == 1) ? "R3" : "R5", "sw_code", int'(sw_code), esw);
    chk("R2", "clr_res", int'(clr_res), (m_ph == 0 && st) ? 1 : 0);
    chk("R4", "phase", int'(phase), m_ph);
    chk("R8", "done", int'(done), (m_ph == 3) ? 1 : 0);
    chk(m_sat ? "R7" : "R6", "result", int'($signed(result)), m_res);
    // model the clock edge
    case (m_ph)
      0: if (st) begin m_ph = 1; m_cnt = 0; m_sum = 0; m_lsb = 0; end
      1: begin
        m_sum += dd;
        if (m_cnt == NCO - 1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
      end
      2: begin
        m_lsb += dd * (1 << (N_LSB - 1 - m_cnt));
        if (m_cnt == N_LSB - 1) begin
          full = longint'(m_sum) * (longint'(1) << N_LSB) + longint'(m_lsb);
          m_sat = 1;
          if (full > (longint'(1) << (OUT_W - 1)) - 1) full = (longint'(1) << (OUT_W - 1)) - 1;
          else if (full < -(longint'(1) << (OUT_W - 1))) full = -(longint'(1) << (OUT_W - 1));
          else m_sat = 0;
          m_res = int'(full);
          m_ph = 3; m_cnt = 0;
        end else m_cnt++;
      end
      default: m_ph = 0;
    endcase
  endtask

  // mode: 0 zeros, 1 all +1, 2 all -1, 3 random, 4 top boundary, 5 both-high mix
  task automatic convert(input string name, input int mode, input bit busy_starts);
    int d;
    bit both;
    ctx = name;
    step(1, 0, 0);
    for (int k = 0; k < NCO + N_LSB; k++) begin
      both = 0;
      case (mode)
        0: d = 0;
        1: d = 1;
        2: d = -1;
        4: d = (k == NCO - 1) ? 0 : 1;
        5: begin d = $urandom_range(0, 2) - 1; both = (k % 3 == 0); end
        default: d = $urandom_range(0, 2) - 1;
      endcase
      step(busy_starts && (k % 5 == 2), d, both);
    end
    step(busy_starts, 0, 0);  // done cycle
    step(0, 0, 0);
    step(0, 1, 0);            // idle: inputs have no effect
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ctx = "reset";
    step(0, 0, 0);
    convert("zeros", 0, 0);
    convert("R7 all-plus", 1, 0);
    convert("R7 all-minus", 2, 0);
    convert("top-boundary", 4, 0);
    convert("R1 both-high", 5, 0);
    convert("R9 start-while-busy", 3, 1);
    for (int r = 0; r < 4; r++) convert("random", 3, 0);
    finish_run();
  end
endmodule